// File: doc/BRIEF.md
# Bootstrap Token Replay Sequencer

This block brings a dataflow machine up from reset with no help from software. Once reset is released it walks a program image held in a synchronous ROM. It begins at a fixed base address and emits the image as two-flit tokens on a shared 16-bit bus under a valid/ready handshake. Each image entry is two adjacent ROM cells. The cell at the lower address becomes the first flit and the next cell becomes the second flit. The block never looks inside a flit. Instruction-memory load tokens, seed tokens and anything else are opaque data to it, and they leave in exactly the order they are stored.

How many entries to send is given on `entry_total`, which is sampled once in the first cycle after reset. The sequencer is an address counter, a remaining-entry counter and a small state machine. The states and their transitions are:

- START: loads the entry count. It goes to DONE when the count is zero and to FETCH_HEAD otherwise.
- FETCH_HEAD: presents the first-flit address to the ROM. It always moves to SEND_HEAD.
- SEND_HEAD: offers the first flit and stays there until `tok_ready`. On acceptance it moves to FETCH_TAIL.
- FETCH_TAIL: presents the second-flit address. It always moves to SEND_TAIL.
- SEND_TAIL: offers the second flit with `tok_last` high. On acceptance it goes to DONE if that was the final entry and back to FETCH_HEAD otherwise.
- DONE: raises `done` and stays until the next reset.

The ROM has one cycle of read latency. The address is held steady while a flit is offered, so the flit on the bus stays steady too.

Top module: `boot_replay_seq`

## Requirements
- R1: While reset is asserted, `tok_valid` and `done` are 0 and `rom_addr` equals the base address (default 0x200).
- R2: `tok_valid` is first raised two clock edges after reset release. After each accepted flit, `tok_valid` drops for exactly one cycle (the fetch cycle) and then rises again, unless the image is finished.
- R3: While `tok_valid` is 1 and `tok_ready` is 0, the flit, `tok_last` and the ROM address stay unchanged, and `tok_valid` stays 1.
- R4: Entry k (counting from 0) is sent as the cell at base+2k followed by the cell at base+2k+1. `tok_last` is 0 on the first flit and 1 on the second. The ROM address advances by one on every accepted flit.
- R5: Exactly `entry_total` entries (2×`entry_total` flits) are accepted. The count is sampled in the first cycle after reset release.
- R6: `done` rises in the cycle after the final second flit is accepted. From then until reset, `done` stays 1 and `tok_valid` stays 0.
- R7: With `entry_total` = 0, `done` is 1 from the first cycle after reset release, and no flit is ever offered.
- R8: Flit values reach the bus unaltered, whatever their bit patterns. This includes load tokens with bits 15:11 = 01101 and words with bit 15 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_total | input | CNT_W (8) | Number of image entries to replay, sampled after reset |
| rom_addr | output | ADDR_W (10) | Address of the ROM cell being read |
| rom_data | input | DATA_W (16) | Synchronous ROM read data, one cycle after `rom_addr` |
| tok_valid | output | 1 | A flit is offered on `tok_flit` |
| tok_ready | input | 1 | The bus accepts the offered flit this cycle |
| tok_flit | output | DATA_W (16) | Flit data |
| tok_last | output | 1 | The offered flit is the second flit of its token |
| done | output | 1 | Replay finished; sticky until reset |

## Verification
The assertions check on every cycle the properties that hold locally in time. A stalled flit must hold its address and framing. The address must step on each acceptance. A first flit must be followed by a fetch bubble and then a second flit. `done` must stay set with the bus quiet, and the remaining count must never be decremented below zero. The bench scenarios show the properties that depend on the whole image: every flit matches its ROM cell in order, the number of entries sent matches the sampled count, a count of zero produces no traffic at all, and arbitrary bit patterns pass through unchanged under back-to-back, random and heavily stalled ready patterns.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        BS_START      = 3'd0,
        BS_FETCH_HEAD = 3'd1,
        BS_SEND_HEAD  = 3'd2,
        BS_FETCH_TAIL = 3'd3,
        BS_SEND_TAIL  = 3'd4,
        BS_DONE       = 3'd5
    } boot_state_e;

endpackage

// File: rtl/boot_addr_ctr.sv
module boot_addr_ctr #(
    parameter int unsigned ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= BASE_ADDR;
        end else if (step) begin
            addr <= addr + ONE;
        end
    end

endmodule

// File: rtl/boot_entry_ctr.sv
module boot_entry_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             final_entry
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec) begin
            left_q <= left_q - ONE;
        end
    end

    assign final_entry = (left_q == ONE);

    // R5: never consume an entry that was not counted in
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (left_q != '0));

endmodule

// File: rtl/boot_replay_seq.sv
module boot_replay_seq
    import boot_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CNT_W     = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  entry_total,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_data,
    output logic              tok_valid,
    input  logic              tok_ready,
    output logic [DATA_W-1:0] tok_flit,
    output logic              tok_last,
    output logic              done
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    boot_state_e state_q, state_d;
    logic        step;
    logic        cnt_load;
    logic        cnt_dec;
    logic        final_entry;

    boot_addr_ctr #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .addr  (rom_addr)
    );

    boot_entry_ctr #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cnt_load),
        .load_val    (entry_total),
        .dec         (cnt_dec),
        .final_entry (final_entry)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_START;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_START:      state_d = (entry_total == '0) ? BS_DONE : BS_FETCH_HEAD;
            BS_FETCH_HEAD: state_d = BS_SEND_HEAD;
            BS_SEND_HEAD:  if (tok_ready) state_d = BS_FETCH_TAIL;
            BS_FETCH_TAIL: state_d = BS_SEND_TAIL;
            BS_SEND_TAIL:  if (tok_ready) state_d = final_entry ? BS_DONE : BS_FETCH_HEAD;
            BS_DONE:       state_d = BS_DONE;
            default:       state_d = BS_DONE;
        endcase
    end

    // outputs
    always_comb begin
        tok_valid = 1'b0;
        tok_last  = 1'b0;
        done      = 1'b0;
        step      = 1'b0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        unique case (state_q)
            BS_START:      cnt_load = 1'b1;
            BS_FETCH_HEAD: ;
            BS_SEND_HEAD: begin
                tok_valid = 1'b1;
                step      = tok_ready;
            end
            BS_FETCH_TAIL: ;
            BS_SEND_TAIL: begin
                tok_valid = 1'b1;
                tok_last  = 1'b1;
                step      = tok_ready;
                cnt_dec   = tok_ready;
            end
            BS_DONE:       done = 1'b1;
            default:       done = 1'b1;
        endcase
    end

    // flits are opaque: passed straight from the held ROM word
    assign tok_flit = rom_data;

    // R3: a refused flit keeps its framing and source address
    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !tok_ready) |=> (tok_valid && $stable(tok_last) && $stable(rom_addr)));

    // R4: each accepted flit moves the read pointer by one cell
    a_r4_step_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready) |=> (rom_addr == $past(rom_addr) + ADDR_ONE));

    // R4: a first flit is followed by a fetch bubble, then its second flit
    a_r4_head_then_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready && !tok_last) |=> !tok_valid ##1 (tok_valid && tok_last));

    // R6: completion is sticky
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R6: the bus is quiet once finished
    a_r6_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tok_valid);

endmodule

// File: tb/boot_replay_seq_test.sv
`timescale 1ns/1ps
module boot_replay_seq_test;

    localparam int unsigned ADDR_W = 10;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned CNT_W  = 8;
    localparam logic [ADDR_W-1:0] BASE = 10'h200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  entry_total = '0;
    logic [ADDR_W-1:0] rom_addr;
    logic [DATA_W-1:0] rom_data = '0;
    logic              tok_valid;
    logic              tok_ready = 1'b0;
    logic [DATA_W-1:0] tok_flit;
    logic              tok_last;
    logic              done;

    logic [DATA_W-1:0] rom [0:(1<<ADDR_W)-1];

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) rom_data <= rom[rom_addr];

    boot_replay_seq #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CNT_W (CNT_W), .BASE_ADDR (BASE)
    ) uut (
        .clk (clk), .rst_n (rst_n), .entry_total (entry_total),
        .rom_addr (rom_addr), .rom_data (rom_data),
        .tok_valid (tok_valid), .tok_ready (tok_ready),
        .tok_flit (tok_flit), .tok_last (tok_last), .done (done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // mode 0: always ready, 1: random ready, 2: long stalls
    task automatic replay(input int n, input int mode);
        logic [DATA_W-1:0] q[$];
        int idx = 0;
        bit m_valid = 1'b0;
        bit m_done;
        bit prev_hold = 1'b0;
        logic [DATA_W-1:0] prev_flit = '0;
        int post = 0;
        for (int i = 0; i < 2*n; i++) begin
            logic [DATA_W-1:0] v;
            if (i % 2 == 1)      v = 16'(i*40503 + 7 + n);
            else if (i < n)      v = {5'b01101, 11'(i*37 + n)};
            else                 v = {1'b1, 15'(i*4099 + n)};
            q.push_back(v);
            rom[int'(BASE) + i] = v;
        end
        rom[int'(BASE) + 2*n] = 16'hDEAD;
        @(negedge clk);
        rst_n = 1'b0;
        tok_ready = 1'b0;
        entry_total = CNT_W'(n);
        repeat (3) @(negedge clk);
        check(tok_valid == 1'b0, "R1 valid in reset", int'(tok_valid), 0);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        check(rom_addr == BASE, "R1 address in reset", int'(rom_addr), int'(BASE));
        rst_n = 1'b1;
        m_done = (n == 0);
        for (int cyc = 0; cyc < 4000 && post < 6; cyc++) begin
            @(negedge clk);
            check(tok_valid == m_valid, "R2 valid timing", int'(tok_valid), int'(m_valid));
            check(done == m_done, (n == 0) ? "R7 done" : "R6 done", int'(done), int'(m_done));
            if (m_valid && tok_valid) begin
                check(tok_flit == q[idx], "R4 R8 flit value", int'(tok_flit), int'(q[idx]));
                check(tok_last == idx[0], "R4 last marker", int'(tok_last), idx % 2);
            end
            if (prev_hold)
                check(tok_flit == prev_flit, "R3 held flit", int'(tok_flit), int'(prev_flit));
            if (m_done) post++;
            case (mode)
                0:       tok_ready = 1'b1;
                1:       tok_ready = 1'($urandom_range(0, 1));
                default: tok_ready = (cyc % 7 == 6);
            endcase
            prev_hold = tok_valid && !tok_ready;
            prev_flit = tok_flit;
            if (m_valid && tok_ready) begin
                idx++;
                m_valid = 1'b0;
                if (idx == 2*n) m_done = 1'b1;
            end else if (!m_valid && !m_done) begin
                m_valid = 1'b1;
            end
        end
        check(idx == 2*n, "R5 flits accepted", idx, 2*n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R5 watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int a = 0; a < (1<<ADDR_W); a++) rom[a] = 16'hFFFF;
        replay(3, 0);
        replay(4, 1);
        replay(0, 0);  // R7
        replay(1, 2);
        replay(6, 1);
        replay(2, 2);
        replay(9, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule